// File: doc/BRIEF.md
# Paged Virtual Address Translator

This block turns a 16-bit virtual address into a physical address. It uses a bank of page base and page descriptor registers, one pair for each combination of privilege mode, address space and segment. The top three bits of the virtual address pick a segment. The middle seven bits are a block number, which is added to the selected page base. The low six bits pass through unchanged as the displacement. The result is 22 bits wide when extended addressing is on. When it is off, the result is 18 bits wide and only the low 12 bits of the page base are used.

Each request is checked in two ways. The first check is against the page length, and its sense depends on which way the page expands. The second check is against a three-bit access-control code in the descriptor. A failed check gives an abort one cycle later. The abort carries a reason code, the segment, the space actually used and the mode. Some access-control codes do not abort but raise a management-trap flag instead; the processor acts on that flag when the current instruction ends. A request that passes both checks sets the descriptor's accessed flag, and a write request also sets its written flag.

Data-space requests fall back to the instruction-space registers when the control word does not enable separate data space for that mode. A simple write port loads the registers, and a combinational read port returns them.

Top module: `paged_xlat`

## Requirements
- R1: When `reloc_en` is low, a request returns `rsp_pa` equal to the virtual address with zero upper bits. It raises no abort and no trap, and it changes no descriptor.
- R2: Each request gets a response on the next clock edge (`rsp_valid`). With extended addressing on (`ctl_word[4]`=1), `rsp_pa` = ((page base + va[12:6]) << 6) | va[5:0], truncated to 22 bits. The segment is va[15:13].
- R3: With extended addressing off, only bits 11:0 of the page base are used, and `rsp_pa` is truncated to 18 bits (bits 21:18 read zero).
- R4: When descriptor bit 3 is clear (upward expansion), a block number greater than the length field (descriptor bits 14:8) aborts with reason length.
- R5: When descriptor bit 3 is set (downward expansion), a block number less than the length field aborts with reason length.
- R6: For access-control codes (descriptor bits 2:0) 0, 3 and 7, every access aborts with reason no-access. For codes 1 and 2, a write aborts with reason read-only.
- R7: `rsp_mgmt_trap` is raised for code 1 on a read, for code 4 on any access, and for code 5 on a write, provided the request does not abort. No other case raises it.
- R8: Mode encoding: 0 is kernel, 1 is supervisor, 3 is user. Control-word bits 2, 1 and 0 enable separate data space for kernel, supervisor and user respectively. If that bit is clear, or the mode is 2, a data request uses the instruction-space registers.
- R9: `rsp_why` is one-hot when an abort occurs: 100 = no-access, 010 = length, 001 = read-only. An access-control abort takes priority over a length abort. `rsp_seg`, `rsp_space` (after folding) and `rsp_mode` identify the request, and `rsp_pa` is zero on an abort.
- R10: A request that succeeds sets descriptor bit 7. A successful write also sets bit 6. A request that aborts leaves both bits unchanged.
- R11: Any write to a page base or a descriptor stores the data and clears bits 7:6 of that pair's descriptor. The register index is {mode, space, segment}.
- R12: After reset, `rsp_valid`, `rsp_abort` and `rsp_mgmt_trap` are low, and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reloc_en | input | 1 | Relocation enable |
| ctl_word | input | 16 | Control word: bits 2/1/0 enable separate data space, bit 4 enables extended addressing |
| req_valid | input | 1 | Request strobe |
| req_va | input | 16 | Virtual address |
| req_mode | input | 2 | Privilege mode |
| req_dspace | input | 1 | 1 = data-space request |
| req_write | input | 1 | 1 = write access |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_pa | output | 22 | Physical address |
| rsp_abort | output | 1 | Request aborted |
| rsp_why | output | 3 | One-hot abort reason |
| rsp_seg | output | 3 | Segment of the request |
| rsp_space | output | 1 | Space actually used |
| rsp_mode | output | 2 | Mode of the request |
| rsp_mgmt_trap | output | 1 | Management trap to be taken at the end of the instruction |
| dw_en | input | 1 | Register write strobe |
| dw_is_pdr | input | 1 | 1 = descriptor, 0 = page base |
| dw_mode | input | 2 | Write target mode |
| dw_space | input | 1 | Write target space |
| dw_seg | input | 3 | Write target segment |
| dw_data | input | 16 | Write data |
| dr_is_pdr | input | 1 | Read select: descriptor or page base |
| dr_mode | input | 2 | Read target mode |
| dr_space | input | 1 | Read target space |
| dr_seg | input | 3 | Read target segment |
| dr_data | output | 16 | Combinational read data |

## Verification
All response fields and the accessed and written flags are updated on the same clock edge that follows the request strobe. The bench therefore drives each request on a falling edge and samples every response field one falling edge later. The descriptor read port is combinational, so the bench reads it back at that same falling edge. Register writes take effect at the next rising edge, and the bench issues each new request only after that edge.

// File: rtl/paged_xlat_pkg.sv
// Shared constants and helpers for the paged address translator.
// Assumes mode encoding 0=kernel, 1=supervisor, 3=user (2 is unused).
package paged_xlat_pkg;
    localparam int VA_W    = 16;
    localparam int SEG_W   = 3;
    localparam int BN_W    = 7;
    localparam int DISP_W  = 6;
    localparam int MODE_W  = 2;
    localparam int REG_W   = 16;
    localparam int PA_W    = 22;
    localparam int PA18_W  = 18;
    localparam int IDX_W   = MODE_W + 1 + SEG_W;
    localparam int ENTRIES = 1 << IDX_W;

    localparam logic [2:0] WHY_NONE = 3'b000;
    localparam logic [2:0] WHY_NR   = 3'b100;
    localparam logic [2:0] WHY_LEN  = 3'b010;
    localparam logic [2:0] WHY_RO   = 3'b001;

    // Resolve the space actually used: data space only if enabled for the mode.
    function automatic logic fold_space(input logic [MODE_W-1:0] mode,
                                        input logic dspace,
                                        input logic [REG_W-1:0] ctl);
        logic en;
        case (mode)
            2'd0:    en = ctl[2];
            2'd1:    en = ctl[1];
            2'd3:    en = ctl[0];
            default: en = 1'b0;
        endcase
        return dspace & en;
    endfunction
endpackage

// File: rtl/paged_xlat_regs.sv
// Page base / descriptor register bank.
// One page base and one descriptor per entry. A host write stores data and
// clears the pair's accessed/written flags; a host write wins over a flag
// update in the same cycle. Flag updates only ever set bits 7 and 6.
module paged_xlat_regs #(
    parameter int IDX_W = 6,
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_is_pdr,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [REG_W-1:0] wr_data,
    input  logic             fl_set,
    input  logic             fl_write,
    input  logic [IDX_W-1:0] fl_idx,
    input  logic [IDX_W-1:0] x_idx,
    output logic [REG_W-1:0] x_par,
    output logic [REG_W-1:0] x_pdr,
    input  logic             rd_is_pdr,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [REG_W-1:0] rd_data
);
    localparam int N = 1 << IDX_W;

    logic [REG_W-1:0] par_q [N];
    logic [REG_W-1:0] pdr_q [N];

    for (genvar i = 0; i < N; i++) begin : g_ent
        // Page base storage for entry i.
        always_ff @(posedge clk) begin
            if (!rst_n)
                par_q[i] <= '0;
            else if (wr_en && !wr_is_pdr && wr_idx == IDX_W'(i))
                par_q[i] <= wr_data;
        end

        // Descriptor storage for entry i: host write first, then flag set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pdr_q[i] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                if (wr_is_pdr)
                    pdr_q[i] <= wr_data & ~REG_W'(16'h00C0);
                else
                    pdr_q[i][7:6] <= 2'b00;
            end else if (fl_set && fl_idx == IDX_W'(i)) begin
                pdr_q[i][7] <= 1'b1;
                if (fl_write)
                    pdr_q[i][6] <= 1'b1;
            end
        end
    end

    // Read paths for translation and for the host.
    always_comb begin
        x_par   = par_q[x_idx];
        x_pdr   = pdr_q[x_idx];
        rd_data = rd_is_pdr ? pdr_q[rd_idx] : par_q[rd_idx];
    end
endmodule

// File: rtl/paged_xlat_check.sv
// Descriptor checks: access-control decode and page-length comparison.
// Purely combinational; the caller gates the results with relocation enable.
module paged_xlat_check #(
    parameter int REG_W = 16,
    parameter int BN_W  = 7
) (
    input  logic [REG_W-1:0] pdr,
    input  logic [BN_W-1:0]  bn,
    input  logic             is_write,
    output logic             ab_nr,
    output logic             ab_ro,
    output logic             ab_len,
    output logic             trap
);
    logic [2:0]      acc;
    logic [BN_W-1:0] plen;
    logic            down;

    // Field extraction.
    always_comb begin
        acc  = pdr[2:0];
        down = pdr[3];
        plen = pdr[8 +: BN_W];
    end

    // Access-control code decode into aborts and deferred trap.
    always_comb begin
        ab_nr = 1'b0;
        ab_ro = 1'b0;
        trap  = 1'b0;
        case (acc)
            3'd0, 3'd3, 3'd7: ab_nr = 1'b1;
            3'd1: begin
                ab_ro = is_write;
                trap  = !is_write;
            end
            3'd2:    ab_ro = is_write;
            3'd4:    trap  = 1'b1;
            3'd5:    trap  = is_write;
            default: ;
        endcase
    end

    // Length check; sense depends on expansion direction.
    always_comb begin
        ab_len = down ? (bn < plen) : (bn > plen);
    end
endmodule

// File: rtl/paged_xlat_addr.sv
// Physical address formation: ((base + block) << 6) | displacement.
// In 18-bit mode the base is cut to 12 bits and the result to 18 bits.
module paged_xlat_addr #(
    parameter int REG_W  = 16,
    parameter int BN_W   = 7,
    parameter int DISP_W = 6,
    parameter int PA_W   = 22,
    parameter int PA18_W = 18
) (
    input  logic [REG_W-1:0]  par,
    input  logic [BN_W-1:0]   bn,
    input  logic [DISP_W-1:0] disp,
    input  logic              ext,
    output logic [PA_W-1:0]   pa
);
    localparam int SUM_W = REG_W + 1;
    localparam int FULL_W = SUM_W + DISP_W;

    logic [REG_W-1:0]  base;
    logic [SUM_W-1:0]  sum;
    logic [FULL_W-1:0] full;

    // Base masking, block add and truncation to the active width.
    always_comb begin
        base = ext ? par : (par & REG_W'(16'h0FFF));
        sum  = SUM_W'(base) + SUM_W'(bn);
        full = {sum, disp};
        pa   = full[PA_W-1:0];
        if (!ext)
            pa[PA_W-1:PA18_W] = '0;
    end
endmodule

// File: rtl/paged_xlat.sv
// Paged virtual address translator (top).
// Splits the virtual address, folds data space per mode, runs descriptor
// checks and address formation, and registers every result one cycle after
// the request. Successful translations set accessed/written flags.
module paged_xlat
    import paged_xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reloc_en,
    input  logic [REG_W-1:0]  ctl_word,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic [MODE_W-1:0] req_mode,
    input  logic              req_dspace,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              rsp_abort,
    output logic [2:0]        rsp_why,
    output logic [SEG_W-1:0]  rsp_seg,
    output logic              rsp_space,
    output logic [MODE_W-1:0] rsp_mode,
    output logic              rsp_mgmt_trap,
    input  logic              dw_en,
    input  logic              dw_is_pdr,
    input  logic [MODE_W-1:0] dw_mode,
    input  logic              dw_space,
    input  logic [SEG_W-1:0]  dw_seg,
    input  logic [REG_W-1:0]  dw_data,
    input  logic              dr_is_pdr,
    input  logic [MODE_W-1:0] dr_mode,
    input  logic              dr_space,
    input  logic [SEG_W-1:0]  dr_seg,
    output logic [REG_W-1:0]  dr_data
);
    logic [SEG_W-1:0]  seg;
    logic [BN_W-1:0]   bn;
    logic [DISP_W-1:0] disp;
    logic              space;
    logic [IDX_W-1:0]  x_idx;
    logic [REG_W-1:0]  x_par, x_pdr;
    logic              ab_nr, ab_ro, ab_len, chk_trap;
    logic [PA_W-1:0]   map_pa;
    logic              abort_d, trap_d, ok_d;
    logic [2:0]        why_d;
    logic [PA_W-1:0]   pa_d;

    // Address split and space folding.
    always_comb begin
        seg   = req_va[VA_W-1 -: SEG_W];
        bn    = req_va[DISP_W +: BN_W];
        disp  = req_va[DISP_W-1:0];
        space = fold_space(req_mode, req_dspace, ctl_word);
        x_idx = {req_mode, space, seg};
    end

    paged_xlat_regs #(.IDX_W(IDX_W), .REG_W(REG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (dw_en),
        .wr_is_pdr (dw_is_pdr),
        .wr_idx    ({dw_mode, dw_space, dw_seg}),
        .wr_data   (dw_data),
        .fl_set    (ok_d),
        .fl_write  (req_write),
        .fl_idx    (x_idx),
        .x_idx     (x_idx),
        .x_par     (x_par),
        .x_pdr     (x_pdr),
        .rd_is_pdr (dr_is_pdr),
        .rd_idx    ({dr_mode, dr_space, dr_seg}),
        .rd_data   (dr_data)
    );

    paged_xlat_check #(.REG_W(REG_W), .BN_W(BN_W)) u_check (
        .pdr      (x_pdr),
        .bn       (bn),
        .is_write (req_write),
        .ab_nr    (ab_nr),
        .ab_ro    (ab_ro),
        .ab_len   (ab_len),
        .trap     (chk_trap)
    );

    paged_xlat_addr #(.REG_W(REG_W), .BN_W(BN_W), .DISP_W(DISP_W),
                      .PA_W(PA_W), .PA18_W(PA18_W)) u_addr (
        .par  (x_par),
        .bn   (bn),
        .disp (disp),
        .ext  (ctl_word[4]),
        .pa   (map_pa)
    );

    // Combine checks: access-control aborts outrank the length abort.
    always_comb begin
        if (ab_nr)       why_d = WHY_NR;
        else if (ab_ro)  why_d = WHY_RO;
        else if (ab_len) why_d = WHY_LEN;
        else             why_d = WHY_NONE;
        if (!reloc_en) begin
            abort_d = 1'b0;
            trap_d  = 1'b0;
            why_d   = WHY_NONE;
            pa_d    = PA_W'(req_va);
        end else begin
            abort_d = (why_d != WHY_NONE);
            trap_d  = chk_trap && !abort_d;
            pa_d    = abort_d ? '0 : map_pa;
        end
        ok_d = req_valid && reloc_en && !abort_d;
    end

    // Response register, one cycle after the request strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_pa        <= '0;
            rsp_abort     <= 1'b0;
            rsp_why       <= WHY_NONE;
            rsp_seg       <= '0;
            rsp_space     <= 1'b0;
            rsp_mode      <= '0;
            rsp_mgmt_trap <= 1'b0;
        end else begin
            rsp_valid     <= req_valid;
            rsp_pa        <= pa_d;
            rsp_abort     <= req_valid && abort_d;
            rsp_why       <= req_valid ? why_d : WHY_NONE;
            rsp_seg       <= seg;
            rsp_space     <= space;
            rsp_mode      <= req_mode;
            rsp_mgmt_trap <= req_valid && trap_d;
        end
    end
endmodule

// File: rtl/paged_xlat_chk.sv
// Assertion checker for paged_xlat, attached through bind.
module paged_xlat_chk
    import paged_xlat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reloc_en,
    input logic              req_valid,
    input logic [VA_W-1:0]   req_va,
    input logic              rsp_valid,
    input logic [PA_W-1:0]   rsp_pa,
    input logic              rsp_abort,
    input logic [2:0]        rsp_why,
    input logic              rsp_mgmt_trap
);
    // R2: a response follows every request by one cycle.
    p_rsp_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R1: relocation off passes the address through untouched.
    p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !reloc_en) |=> (!rsp_abort && !rsp_mgmt_trap
                                      && rsp_pa == PA_W'($past(req_va))));
    // R9: abort reason is one-hot and the address is zero.
    p_why_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_abort |-> ($countones(rsp_why) == 1 && rsp_pa == '0));
    // R7: a management trap never accompanies an abort.
    p_trap_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_abort |-> !rsp_mgmt_trap);
    // R12: no abort or trap without a response.
    p_quiet_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_abort && !rsp_mgmt_trap));
endmodule

bind paged_xlat paged_xlat_chk u_chk (.*);

// File: tb/paged_xlat_bench.sv
module paged_xlat_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reloc_en = 1'b0;
    logic [15:0] ctl_word = '0;
    logic        req_valid = 1'b0;
    logic [15:0] req_va = '0;
    logic [1:0]  req_mode = '0;
    logic        req_dspace = 1'b0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic [21:0] rsp_pa;
    logic        rsp_abort;
    logic [2:0]  rsp_why;
    logic [2:0]  rsp_seg;
    logic        rsp_space;
    logic [1:0]  rsp_mode;
    logic        rsp_mgmt_trap;
    logic        dw_en = 1'b0;
    logic        dw_is_pdr = 1'b0;
    logic [1:0]  dw_mode = '0;
    logic        dw_space = 1'b0;
    logic [2:0]  dw_seg = '0;
    logic [15:0] dw_data = '0;
    logic        dr_is_pdr = 1'b0;
    logic [1:0]  dr_mode = '0;
    logic        dr_space = 1'b0;
    logic [2:0]  dr_seg = '0;
    logic [15:0] dr_data;

    int total = 0;
    int bad = 0;
    logic [15:0] par_m [64];
    logic [15:0] pdr_m [64];

    always #5 clk = ~clk;

    paged_xlat u_paged_xlat (.*);

    function automatic logic fold_m(input logic [1:0] m, input logic d, input logic [15:0] c);
        logic e;
        e = (m == 2'd0) ? c[2] : (m == 2'd1) ? c[1] : (m == 2'd3) ? c[0] : 1'b0;
        return d & e;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic p, input logic [1:0] m, input logic s,
                             input logic [2:0] g, input logic [15:0] d);
        int i;
        @(negedge clk);
        dw_en = 1'b1; dw_is_pdr = p; dw_mode = m; dw_space = s; dw_seg = g; dw_data = d;
        @(negedge clk);
        dw_en = 1'b0;
        i = {m, s, g};
        if (p) pdr_m[i] = d & 16'hFF3F;
        else begin par_m[i] = d; pdr_m[i][7:6] = 2'b00; end
    endtask

    task automatic read_pdr(input logic [1:0] m, input logic s, input logic [2:0] g,
                            output logic [15:0] v);
        dr_is_pdr = 1'b1; dr_mode = m; dr_space = s; dr_seg = g;
        #1 v = dr_data;
    endtask

    // Request plus full comparison against the bench model.
    task automatic xreq(input string tag, input logic [15:0] va, input logic [1:0] m,
                        input logic d, input logic w);
        logic sp, ab, tr, dn, ext;
        logic [2:0] why, acc;
        logic [6:0] bn, pl;
        logic [15:0] base, pdrv, rb;
        logic [22:0] full;
        logic [21:0] pa;
        int i;
        sp = fold_m(m, d, ctl_word);
        i = {m, sp, va[15:13]};
        pdrv = pdr_m[i]; acc = pdrv[2:0]; dn = pdrv[3]; pl = pdrv[14:8]; bn = va[12:6];
        ext = ctl_word[4];
        why = 3'b000; tr = 1'b0;
        if (acc == 0 || acc == 3 || acc == 7) why = 3'b100;
        else if ((acc == 1 || acc == 2) && w) why = 3'b001;
        else if (dn ? (bn < pl) : (bn > pl)) why = 3'b010;
        if (!reloc_en) why = 3'b000;
        ab = (why != 0);
        if (reloc_en && !ab)
            tr = (acc == 1 && !w) || acc == 4 || (acc == 5 && w);
        base = ext ? par_m[i] : (par_m[i] & 16'h0FFF);
        full = {({1'b0, base} + 17'(bn)), va[5:0]};
        pa = full[21:0];
        if (!ext) pa[21:18] = 4'd0;
        if (!reloc_en) pa = {6'd0, va};
        else if (ab) pa = '0;
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_mode = m; req_dspace = d; req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " rsp"}, {rsp_valid, rsp_abort, rsp_why, rsp_mgmt_trap, 4'd0, rsp_pa},
                           {1'b1, ab, why, tr, 4'd0, pa});
        if (ab) chk({tag, " R9 info"}, {rsp_seg, rsp_space, rsp_mode}, {va[15:13], sp, m});
        if (reloc_en && !ab) pdr_m[i] = pdr_m[i] | (w ? 16'h00C0 : 16'h0080);
        read_pdr(m, sp, va[15:13], rb);
        chk({tag, " R10 flags"}, rb, pdr_m[i]);
    endtask

    function automatic logic [15:0] mkva(input int g, input int b, input int dsp);
        return {3'(g), 7'(b), 6'(dsp)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        process::self().srandom(32'h5eed1234);
        for (int i = 0; i < 64; i++) begin par_m[i] = '0; pdr_m[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset valid", {rsp_valid, rsp_abort, rsp_mgmt_trap}, 3'b000);
        read_pdr(2'd3, 1'b1, 3'd7, v);
        chk("R12 reset regs", v, 16'h0);

        // R1 relocation off
        cfg_write(1, 0, 0, 5, 16'h7F06);
        xreq("R1 passthru", 16'hABCD, 0, 0, 1);
        chk("R1 pa literal", rsp_pa, 22'h00ABCD);

        // R2 / R3 address formation
        reloc_en = 1'b1; ctl_word = 16'h0010;
        cfg_write(0, 0, 0, 2, 16'hF123);
        cfg_write(1, 0, 0, 2, 16'h7F06);
        xreq("R2 ext22", mkva(2, 5, 6'h11), 0, 0, 0);
        chk("R2 pa literal", rsp_pa, 22'h3C4A11);
        ctl_word = 16'h0000;
        xreq("R3 ext18", mkva(2, 5, 6'h11), 0, 0, 1);
        chk("R3 pa literal", rsp_pa, 22'h004A11);
        // R11 page base write clears flags
        cfg_write(0, 0, 0, 2, 16'h0042);
        read_pdr(0, 0, 2, v);
        chk("R11 flags cleared", v[7:6], 2'b00);
        chk("R11 pdr kept", v, 16'h7F06);

        // R4 upward length
        cfg_write(1, 1, 0, 1, 16'h0306);
        xreq("R4 bn over", mkva(1, 4, 0), 1, 0, 0);
        chk("R4 why", rsp_why, 3'b010);
        xreq("R4 bn at limit", mkva(1, 3, 0), 1, 0, 0);
        // R5 downward length
        cfg_write(1, 3, 0, 6, 16'h0A0E);
        xreq("R5 bn under", mkva(6, 9, 0), 3, 0, 1);
        chk("R5 why", rsp_why, 3'b010);
        xreq("R5 bn at limit", mkva(6, 10, 0), 3, 0, 1);

        // R6 / R7 access codes
        for (int c = 0; c < 8; c++) begin
            cfg_write(1, 0, 0, 3, 16'h7F00 | 16'(c));
            xreq($sformatf("R6 R7 code%0d rd", c), mkva(3, 1, 2), 0, 0, 0);
            xreq($sformatf("R6 R7 code%0d wr", c), mkva(3, 1, 2), 0, 0, 1);
        end
        // R9 priority: no-access wins over length
        cfg_write(1, 0, 0, 4, 16'h0100);
        xreq("R9 priority", mkva(4, 9, 0), 0, 0, 0);
        chk("R9 why nr", rsp_why, 3'b100);

        // R8 folding
        cfg_write(1, 3, 0, 0, 16'h7F02);
        cfg_write(1, 3, 1, 0, 16'h7F00);
        ctl_word = 16'h0006;
        xreq("R8 user fold to I", mkva(0, 1, 1), 3, 1, 0);
        chk("R8 folded ok", rsp_abort, 1'b0);
        ctl_word = 16'h0001;
        xreq("R8 user D used", mkva(0, 1, 1), 3, 1, 0);
        chk("R8 D space abort", {rsp_abort, rsp_space}, 2'b11);

        // Random mix
        for (int i = 0; i < 64; i++)
            cfg_write($urandom_range(0, 1), 2'(i >> 4), 1'(i >> 3), 3'(i), 16'($urandom));
        for (int i = 0; i < 64; i++)
            cfg_write(1, 2'(i >> 4), 1'(i >> 3), 3'(i), 16'($urandom) | 16'h7000);
        for (int n = 0; n < 1500; n++) begin
            reloc_en = ($urandom_range(0, 9) != 0);
            ctl_word = 16'($urandom) & 16'h0017;
            xreq("R2 R8 random", 16'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
            if ($urandom_range(0, 19) == 0)
                cfg_write($urandom_range(0, 1), 2'($urandom), 1'($urandom), 3'($urandom),
                          16'($urandom));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule